// File: doc/BRIEF.md
# Command/Response Buffer Control Register Block

This block is the device side of a memory-mapped control interface for a trusted security module that exchanges commands and responses through shared buffers. Host software reaches it over a simple 32-bit register bus with a byte address, write data, a write strobe and a combinational read port. Through it, software claims and releases ownership of the interface (a locality), asks the device to become ready for a command or to drop into idle, rings a doorbell to launch a command, and may cancel a running command. The block also publishes the location and size of the command and response buffers, which are fixed at build time.

Toward the command engine the block offers a narrow handshake. A one-cycle `cmd_start` pulse marks a launched command, `cmd_done` reports completion, `cmd_error` flags an unrecoverable fault, and a one-cycle `idle_ack` pulse reports that an idle request has been carried out. Command-ready and go-idle requests are acknowledged after a build-time number of cycles, so that software's poll-until-clear loops see a real delay. The two interrupt registers are plain read/write storage; no interrupt is raised.

Byte offsets: the head area occupies 0x00–0x3F (locality state 0x00, locality control 0x08, locality status 0x0C, interface identifier 0x30/0x34, extension word 0x38/0x3C); the control area follows directly at 0x40 in this order: request 0x40, status 0x44, cancel 0x48, start 0x4C, interrupt enable 0x50, interrupt status 0x54, command size 0x58, command address low 0x5C and high 0x60, response size 0x64, response address low 0x68 and high 0x6C. Any other word reads 0.

Top module: `crb_ctrl_regs`

## Requirements
- R1: After reset, with one clock elapsed, locality state (0x00) reads 0x80 (bit 7 valid set, bit 1 assigned clear), request (0x40) reads 0, status (0x44) reads 0x2 (bit 1 idle set, bit 0 error clear), cancel (0x48) and start (0x4C) read 0.
- R2: A write to locality control (0x08) with bit 0 set and bit 1 clear makes locality state read 0x82 from the next cycle, and locality status (0x0C) bit 0 reads 1.
- R3: A write to locality control with bit 1 set makes locality state read 0x80 from the next cycle and locality status read 0, even if bit 0 is set in the same write; a write with both bits clear leaves ownership unchanged.
- R4: Writing request (0x40) with bit 0 (command-ready) or bit 1 (go-idle) makes that bit read 1 for exactly ACK_DELAY cycles after the write edge, then 0; on clearing, status bit 1 reads 0 after command-ready and 1 after go-idle, and `idle_ack` is high for the one cycle in which a go-idle request first reads cleared.
- R5: A command-ready write while a go-idle request is still pending clears the go-idle bit at once, then completes ACK_DELAY cycles after its own write with the device ready (status bit 1 = 0) and no `idle_ack`; a single write with both bits set is handled as command-ready.
- R6: Status bit 0 becomes 1 the cycle after `cmd_error` is seen high and stays 1 until reset.
- R7: A write to start (0x4C) with bit 0 set while the locality is assigned, the device is ready and no command runs makes start bit 0 read 1 from the next cycle and pulses `cmd_start` for exactly that one cycle; any other start write, including a write of 0, changes nothing and gives no pulse.
- R8: While a command runs, `cmd_done` high at a clock edge makes start read 0 after that edge.
- R9: Cancel bit 0 reads back the last value written; while a command runs and cancel reads 1, start reads 0 one cycle later.
- R10: Interrupt enable (0x50) and interrupt status (0x54) each store a full 32-bit write and read it back.
- R11: Command size, command address, response size and response address words and the interface identifier read their build-time values, ignore writes, and reserved words read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cmd_start | output | 1 | One-cycle pulse when a command is launched |
| cmd_done | input | 1 | Command engine reports completion |
| cmd_error | input | 1 | Command engine reports an unrecoverable fault |
| idle_ack | output | 1 | One-cycle pulse when a go-idle request completes |

## Verification
Every write takes effect at the clock edge on which it is sampled, so locality, start, cancel and storage results are due one cycle after the write and the bench reads them at the falling edge that follows. Request bits stay set for exactly ACK_DELAY cycles counted from the write edge; the bench walks that window one falling edge at a time and expects the bit set for the first ACK_DELAY samples and `idle_ack` only at the sample where the bit first reads clear. Cancellation and completion each take one further edge after the condition is registered, and the bench samples start bit 0 on both sides of that edge.

// File: rtl/crb_pkg.sv
package crb_pkg;

    // Head area byte offsets
    localparam int unsigned OFF_LOC_STATE = 32'h00;
    localparam int unsigned OFF_LOC_CTRL  = 32'h08;
    localparam int unsigned OFF_LOC_STS   = 32'h0C;
    localparam int unsigned OFF_IFID_LO   = 32'h30;
    localparam int unsigned OFF_IFID_HI   = 32'h34;
    localparam int unsigned OFF_EXT_LO    = 32'h38;
    localparam int unsigned OFF_EXT_HI    = 32'h3C;

    // Control area byte offsets (order is fixed by host software)
    localparam int unsigned OFF_REQ       = 32'h40;
    localparam int unsigned OFF_STS       = 32'h44;
    localparam int unsigned OFF_CANCEL    = 32'h48;
    localparam int unsigned OFF_START     = 32'h4C;
    localparam int unsigned OFF_IRQ_EN    = 32'h50;
    localparam int unsigned OFF_IRQ_STS   = 32'h54;
    localparam int unsigned OFF_CMD_SZ    = 32'h58;
    localparam int unsigned OFF_CMD_LO    = 32'h5C;
    localparam int unsigned OFF_CMD_HI    = 32'h60;
    localparam int unsigned OFF_RSP_SZ    = 32'h64;
    localparam int unsigned OFF_RSP_LO    = 32'h68;
    localparam int unsigned OFF_RSP_HI    = 32'h6C;

    // Bit positions decoded by host software
    localparam int unsigned BIT_LOC_GRAB     = 0;
    localparam int unsigned BIT_LOC_DROP     = 1;
    localparam int unsigned BIT_LOC_OWNED    = 1;
    localparam int unsigned BIT_LOC_VALID    = 7;
    localparam int unsigned BIT_REQ_READY    = 0;
    localparam int unsigned BIT_REQ_IDLE     = 1;
    localparam int unsigned BIT_STS_FAULT    = 0;
    localparam int unsigned BIT_STS_IDLE     = 1;
    localparam int unsigned BIT_DOORBELL     = 0;

endpackage

// File: rtl/crb_locality.sv
module crb_locality (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic grab,
    input  logic drop,
    output logic owned,
    output logic valid
);

    typedef struct packed {
        logic owned;
        logic valid;
    } loc_st_t;

    loc_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b1;
        if (wr_en) begin
            if (drop) begin
                st_d.owned = 1'b0;
            end else if (grab) begin
                st_d.owned = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign owned = st_q.owned;
    assign valid = st_q.valid;

endmodule

// File: rtl/crb_readiness.sv
module crb_readiness #(
    parameter int unsigned ACK_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic want_ready,
    input  logic want_idle,
    output logic pend_ready,
    output logic pend_idle,
    output logic dev_ready,
    output logic dev_idle,
    output logic idle_ack
);

    localparam int unsigned CNT_W = (ACK_DELAY < 2) ? 1 : $clog2(ACK_DELAY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 1);

    typedef struct packed {
        logic             pend_ready;
        logic             pend_idle;
        logic             ready;
        logic             idle;
        logic             ack;
        logic [CNT_W-1:0] cnt;
    } rdy_st_t;

    localparam rdy_st_t RST_ST = '{
        pend_ready: 1'b0,
        pend_idle:  1'b0,
        ready:      1'b0,
        idle:       1'b1,
        ack:        1'b0,
        cnt:        '0
    };

    rdy_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;

        // Count down an outstanding request and retire it
        if (st_q.pend_ready || st_q.pend_idle) begin
            if (st_q.cnt == CNT_LAST) begin
                if (st_q.pend_ready) begin
                    st_d.ready = 1'b1;
                    st_d.idle  = 1'b0;
                end else begin
                    st_d.ready = 1'b0;
                    st_d.idle  = 1'b1;
                    st_d.ack   = 1'b1;
                end
                st_d.pend_ready = 1'b0;
                st_d.pend_idle  = 1'b0;
                st_d.cnt        = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        // A new request replaces any outstanding one; ready wins a tie
        if (wr_en && (want_ready || want_idle)) begin
            st_d.pend_ready = want_ready;
            st_d.pend_idle  = want_idle && !want_ready;
            st_d.cnt        = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_ready = st_q.pend_ready;
    assign pend_idle  = st_q.pend_idle;
    assign dev_ready  = st_q.ready;
    assign dev_idle   = st_q.idle;
    assign idle_ack   = st_q.ack;

endmodule

// File: rtl/crb_doorbell.sv
module crb_doorbell (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_start,
    input  logic start_bit,
    input  logic wr_cancel,
    input  logic cancel_bit,
    input  logic launch_ok,
    input  logic cmd_done,
    output logic busy,
    output logic cancel_set,
    output logic launch_pulse
);

    typedef struct packed {
        logic busy;
        logic cancel;
        logic pulse;
    } bell_st_t;

    bell_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;

        if (st_q.busy && (cmd_done || st_q.cancel)) begin
            st_d.busy = 1'b0;
        end

        if (wr_cancel) begin
            st_d.cancel = cancel_bit;
        end

        if (wr_start && start_bit && launch_ok && !st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy         = st_q.busy;
    assign cancel_set   = st_q.cancel;
    assign launch_pulse = st_q.pulse;

endmodule

// File: rtl/crb_ctrl_regs.sv
module crb_ctrl_regs
    import crb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned ACK_DELAY = 4,
    parameter logic [63:0] IFACE_ID  = 64'h0000_0001_1A2B_0041,
    parameter logic [63:0] CMD_ADDR  = 64'h0000_0000_FED4_0080,
    parameter logic [31:0] CMD_BYTES = 32'h0000_0F80,
    parameter logic [63:0] RSP_ADDR  = 64'h0000_0000_FED4_0080,
    parameter logic [31:0] RSP_BYTES = 32'h0000_0F80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    output logic              cmd_start,
    input  logic              cmd_done,
    input  logic              cmd_error,
    output logic              idle_ack
);

    localparam logic [ADDR_W-1:0] A_LOC_STATE = ADDR_W'(OFF_LOC_STATE);
    localparam logic [ADDR_W-1:0] A_LOC_CTRL  = ADDR_W'(OFF_LOC_CTRL);
    localparam logic [ADDR_W-1:0] A_LOC_STS   = ADDR_W'(OFF_LOC_STS);
    localparam logic [ADDR_W-1:0] A_IFID_LO   = ADDR_W'(OFF_IFID_LO);
    localparam logic [ADDR_W-1:0] A_IFID_HI   = ADDR_W'(OFF_IFID_HI);
    localparam logic [ADDR_W-1:0] A_EXT_LO    = ADDR_W'(OFF_EXT_LO);
    localparam logic [ADDR_W-1:0] A_EXT_HI    = ADDR_W'(OFF_EXT_HI);
    localparam logic [ADDR_W-1:0] A_REQ       = ADDR_W'(OFF_REQ);
    localparam logic [ADDR_W-1:0] A_STS       = ADDR_W'(OFF_STS);
    localparam logic [ADDR_W-1:0] A_CANCEL    = ADDR_W'(OFF_CANCEL);
    localparam logic [ADDR_W-1:0] A_START     = ADDR_W'(OFF_START);
    localparam logic [ADDR_W-1:0] A_IRQ_EN    = ADDR_W'(OFF_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_IRQ_STS   = ADDR_W'(OFF_IRQ_STS);
    localparam logic [ADDR_W-1:0] A_CMD_SZ    = ADDR_W'(OFF_CMD_SZ);
    localparam logic [ADDR_W-1:0] A_CMD_LO    = ADDR_W'(OFF_CMD_LO);
    localparam logic [ADDR_W-1:0] A_CMD_HI    = ADDR_W'(OFF_CMD_HI);
    localparam logic [ADDR_W-1:0] A_RSP_SZ    = ADDR_W'(OFF_RSP_SZ);
    localparam logic [ADDR_W-1:0] A_RSP_LO    = ADDR_W'(OFF_RSP_LO);
    localparam logic [ADDR_W-1:0] A_RSP_HI    = ADDR_W'(OFF_RSP_HI);

    typedef struct packed {
        logic        fault;
        logic [31:0] irq_en;
        logic [31:0] irq_sts;
    } top_st_t;

    top_st_t st_d, st_q;

    logic wr_loc, wr_req, wr_cancel, wr_start, wr_irq_en, wr_irq_sts;
    logic loc_assigned, loc_valid;
    logic pend_ready, pend_idle, dev_ready, dev_idle;
    logic start_busy, cancel_q;
    logic error_flag;

    // Write decode
    assign wr_loc     = reg_we && (reg_addr == A_LOC_CTRL);
    assign wr_req     = reg_we && (reg_addr == A_REQ);
    assign wr_cancel  = reg_we && (reg_addr == A_CANCEL);
    assign wr_start   = reg_we && (reg_addr == A_START);
    assign wr_irq_en  = reg_we && (reg_addr == A_IRQ_EN);
    assign wr_irq_sts = reg_we && (reg_addr == A_IRQ_STS);

    crb_locality u_loc (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_loc),
        .grab  (reg_wdata[BIT_LOC_GRAB]),
        .drop  (reg_wdata[BIT_LOC_DROP]),
        .owned (loc_assigned),
        .valid (loc_valid)
    );

    crb_readiness #(
        .ACK_DELAY (ACK_DELAY)
    ) u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_req),
        .want_ready (reg_wdata[BIT_REQ_READY]),
        .want_idle  (reg_wdata[BIT_REQ_IDLE]),
        .pend_ready (pend_ready),
        .pend_idle  (pend_idle),
        .dev_ready  (dev_ready),
        .dev_idle   (dev_idle),
        .idle_ack   (idle_ack)
    );

    crb_doorbell u_bell (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_start     (wr_start),
        .start_bit    (reg_wdata[BIT_DOORBELL]),
        .wr_cancel    (wr_cancel),
        .cancel_bit   (reg_wdata[BIT_DOORBELL]),
        .launch_ok    (loc_assigned && dev_ready),
        .cmd_done     (cmd_done),
        .busy         (start_busy),
        .cancel_set   (cancel_q),
        .launch_pulse (cmd_start)
    );

    // Fault flag and plain storage
    always_comb begin
        st_d = st_q;
        if (cmd_error) begin
            st_d.fault = 1'b1;
        end
        if (wr_irq_en) begin
            st_d.irq_en = reg_wdata;
        end
        if (wr_irq_sts) begin
            st_d.irq_sts = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign error_flag = st_q.fault;

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_LOC_STATE: begin
                reg_rdata[BIT_LOC_OWNED] = loc_assigned;
                reg_rdata[BIT_LOC_VALID] = loc_valid;
            end
            A_LOC_STS:   reg_rdata[0] = loc_assigned;
            A_IFID_LO:   reg_rdata = IFACE_ID[31:0];
            A_IFID_HI:   reg_rdata = IFACE_ID[63:32];
            A_EXT_LO:    reg_rdata = '0;
            A_EXT_HI:    reg_rdata = '0;
            A_REQ: begin
                reg_rdata[BIT_REQ_READY] = pend_ready;
                reg_rdata[BIT_REQ_IDLE]  = pend_idle;
            end
            A_STS: begin
                reg_rdata[BIT_STS_FAULT] = st_q.fault;
                reg_rdata[BIT_STS_IDLE]  = dev_idle;
            end
            A_CANCEL:    reg_rdata[BIT_DOORBELL] = cancel_q;
            A_START:     reg_rdata[BIT_DOORBELL] = start_busy;
            A_IRQ_EN:    reg_rdata = st_q.irq_en;
            A_IRQ_STS:   reg_rdata = st_q.irq_sts;
            A_CMD_SZ:    reg_rdata = CMD_BYTES;
            A_CMD_LO:    reg_rdata = CMD_ADDR[31:0];
            A_CMD_HI:    reg_rdata = CMD_ADDR[63:32];
            A_RSP_SZ:    reg_rdata = RSP_BYTES;
            A_RSP_LO:    reg_rdata = RSP_ADDR[31:0];
            A_RSP_HI:    reg_rdata = RSP_ADDR[63:32];
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crb_ctrl_regs_chk.sv
module crb_ctrl_regs_chk
    import crb_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        wbits,
    input logic              cmd_done,
    input logic              cmd_error,
    input logic              cmd_start,
    input logic              idle_ack,
    input logic              loc_assigned,
    input logic              dev_ready,
    input logic              dev_idle,
    input logic              pend_ready,
    input logic              pend_idle,
    input logic              start_busy,
    input logic              cancel_q,
    input logic              error_flag
);

    logic loc_wr;
    assign loc_wr = reg_we && (reg_addr == ADDR_W'(OFF_LOC_CTRL));

    p_grab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && wbits[0] && !wbits[1]) |=> loc_assigned);

    p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && wbits[1]) |=> !loc_assigned);

    p_one_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_ready, pend_idle}));

    p_ready_xor_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_ready && dev_idle));

    p_ack_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ack |-> (dev_idle && !pend_idle));

    p_fault_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |=> error_flag);

    p_fault_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        error_flag |=> error_flag);

    p_launch_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (start_busy && $past(loc_assigned && dev_ready && !start_busy)));

    p_launch_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_busy && cmd_done) |=> !start_busy);

    p_cancel_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_busy && cancel_q) |=> !start_busy);

endmodule

bind crb_ctrl_regs crb_ctrl_regs_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .wbits        (reg_wdata[1:0]),
    .cmd_done     (cmd_done),
    .cmd_error    (cmd_error),
    .cmd_start    (cmd_start),
    .idle_ack     (idle_ack),
    .loc_assigned (loc_assigned),
    .dev_ready    (dev_ready),
    .dev_idle     (dev_idle),
    .pend_ready   (pend_ready),
    .pend_idle    (pend_idle),
    .start_busy   (start_busy),
    .cancel_q     (cancel_q),
    .error_flag   (error_flag)
);

// File: tb/crb_ctrl_regs_tb.sv
module crb_ctrl_regs_tb;
    import crb_pkg::*;

    localparam int unsigned AW  = 7;
    localparam int unsigned ACK = 4;
    localparam logic [63:0] T_IFID = 64'h0000_0002_55AA_0033;
    localparam logic [63:0] T_CMDA = 64'h0000_0001_FED4_1000;
    localparam logic [31:0] T_CMDS = 32'h0000_0800;
    localparam logic [63:0] T_RSPA = 64'h0000_0001_FED4_2000;
    localparam logic [31:0] T_RSPS = 32'h0000_0400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_rdata;
    logic          cmd_start;
    logic          cmd_done = 1'b0;
    logic          cmd_error = 1'b0;
    logic          idle_ack;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    crb_ctrl_regs #(
        .ADDR_W    (AW),
        .ACK_DELAY (ACK),
        .IFACE_ID  (T_IFID),
        .CMD_ADDR  (T_CMDA),
        .CMD_BYTES (T_CMDS),
        .RSP_ADDR  (T_RSPA),
        .RSP_BYTES (T_RSPS)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .cmd_start (cmd_start),
        .cmd_done  (cmd_done),
        .cmd_error (cmd_error),
        .idle_ack  (idle_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input int unsigned a, input logic [31:0] d);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int unsigned a, input logic [31:0] exp);
        reg_addr = AW'(a);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // Request walk for R4: bit held ACK samples, ack only on the clearing sample
    task automatic req_walk(input string req, input logic [31:0] v, input bit goes_idle);
        wr(OFF_REQ, v);
        for (int k = 0; k <= int'(ACK); k++) begin
            rd_chk(req, OFF_REQ, (k < int'(ACK)) ? v : 32'h0);
            chk(req, {31'd0, idle_ack}, {31'd0, goes_idle && (k == int'(ACK))});
            @(negedge clk);
        end
        chk(req, {31'd0, idle_ack}, 32'h0);
        rd_chk(req, OFF_STS, goes_idle ? 32'h2 : 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finished run");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        rd_chk("R1", OFF_LOC_STATE, 32'h80);
        rd_chk("R1", OFF_REQ,       32'h0);
        rd_chk("R1", OFF_STS,       32'h2);
        rd_chk("R1", OFF_CANCEL,    32'h0);
        rd_chk("R1", OFF_START,     32'h0);
        chk("R1", {30'd0, cmd_start, idle_ack}, 32'h0);

        // R11: read-only words and reserved words ignore writes
        wr(OFF_CMD_SZ, 32'hFFFF_FFFF); rd_chk("R11", OFF_CMD_SZ, T_CMDS);
        wr(OFF_CMD_LO, 32'hFFFF_FFFF); rd_chk("R11", OFF_CMD_LO, T_CMDA[31:0]);
        wr(OFF_CMD_HI, 32'hFFFF_FFFF); rd_chk("R11", OFF_CMD_HI, T_CMDA[63:32]);
        wr(OFF_RSP_SZ, 32'hFFFF_FFFF); rd_chk("R11", OFF_RSP_SZ, T_RSPS);
        wr(OFF_RSP_LO, 32'hFFFF_FFFF); rd_chk("R11", OFF_RSP_LO, T_RSPA[31:0]);
        wr(OFF_RSP_HI, 32'hFFFF_FFFF); rd_chk("R11", OFF_RSP_HI, T_RSPA[63:32]);
        wr(OFF_IFID_LO, 32'h0);        rd_chk("R11", OFF_IFID_LO, T_IFID[31:0]);
        wr(OFF_IFID_HI, 32'h0);        rd_chk("R11", OFF_IFID_HI, T_IFID[63:32]);
        for (int a = 16; a < 48; a += 4) begin
            wr(a, 32'hFFFF_FFFF);
            rd_chk("R11", a, 32'h0);
        end
        rd_chk("R11", OFF_EXT_LO, 32'h0);
        rd_chk("R11", 32'h04, 32'h0);

        // R10: storage words, walking ones and their complements
        for (int b = 0; b < 32; b += 3) begin
            wr(OFF_IRQ_EN,  32'h1 << b);
            wr(OFF_IRQ_STS, ~(32'h1 << b));
            rd_chk("R10", OFF_IRQ_EN,  32'h1 << b);
            rd_chk("R10", OFF_IRQ_STS, ~(32'h1 << b));
        end

        // R2 and R3: every control value from both ownership states
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 4; v++) begin
                logic own;
                wr(OFF_LOC_CTRL, (p == 1) ? 32'h1 : 32'h2);
                wr(OFF_LOC_CTRL, 32'(v));
                own = (v[1]) ? 1'b0 : (v[0] ? 1'b1 : p[0]);
                rd_chk(v[1] ? "R3" : "R2", OFF_LOC_STATE, 32'h80 | (32'(own) << 1));
                rd_chk(v[1] ? "R3" : "R2", OFF_LOC_STS, 32'(own));
            end
        end

        // R4: command-ready then go-idle, cycle by cycle
        req_walk("R4", 32'h1, 1'b0);
        req_walk("R4", 32'h2, 1'b1);

        // R5: ready request while idle request in flight
        wr(OFF_REQ, 32'h2);
        wr(OFF_REQ, 32'h1);
        for (int k = 0; k <= int'(ACK); k++) begin
            rd_chk("R5", OFF_REQ, (k < int'(ACK)) ? 32'h1 : 32'h0);
            chk("R5", {31'd0, idle_ack}, 32'h0);
            @(negedge clk);
        end
        rd_chk("R5", OFF_STS, 32'h0);
        req_walk("R4", 32'h2, 1'b1);
        wr(OFF_REQ, 32'h3);
        rd_chk("R5", OFF_REQ, 32'h1);
        repeat (ACK) @(negedge clk);
        rd_chk("R5", OFF_STS, 32'h0);

        // R7 and R8: launch gate over ownership x readiness
        for (int a = 0; a < 2; a++) begin
            for (int r = 0; r < 2; r++) begin
                logic go;
                wr(OFF_LOC_CTRL, (a == 1) ? 32'h1 : 32'h2);
                wr(OFF_REQ, (r == 1) ? 32'h1 : 32'h2);
                repeat (ACK + 1) @(negedge clk);
                go = a[0] && r[0];
                wr(OFF_START, 32'h1);
                rd_chk("R7", OFF_START, 32'(go));
                chk("R7", {31'd0, cmd_start}, 32'(go));
                @(negedge clk);
                chk("R7", {31'd0, cmd_start}, 32'h0);
                if (go) begin
                    cmd_done = 1'b1;
                    @(negedge clk);
                    cmd_done = 1'b0;
                    rd_chk("R8", OFF_START, 32'h0);
                end
            end
        end

        // R7: writing 0 does nothing; relaunch while running gives no pulse
        wr(OFF_START, 32'h0);
        rd_chk("R7", OFF_START, 32'h0);
        chk("R7", {31'd0, cmd_start}, 32'h0);
        wr(OFF_START, 32'h1);
        chk("R7", {31'd0, cmd_start}, 32'h1);
        wr(OFF_START, 32'h1);
        chk("R7", {31'd0, cmd_start}, 32'h0);
        rd_chk("R7", OFF_START, 32'h1);

        // R9: cancel stops the running command one cycle later
        wr(OFF_CANCEL, 32'h1);
        rd_chk("R9", OFF_CANCEL, 32'h1);
        rd_chk("R9", OFF_START, 32'h1);
        @(negedge clk);
        rd_chk("R9", OFF_START, 32'h0);
        wr(OFF_CANCEL, 32'h0);
        rd_chk("R9", OFF_CANCEL, 32'h0);
        wr(OFF_START, 32'h1);
        repeat (3) @(negedge clk);
        rd_chk("R9", OFF_START, 32'h1);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        rd_chk("R8", OFF_START, 32'h0);

        // R6: sticky fault
        rd_chk("R6", OFF_STS, 32'h0);
        cmd_error = 1'b1;
        @(negedge clk);
        cmd_error = 1'b0;
        rd_chk("R6", OFF_STS, 32'h1);
        repeat (5) @(negedge clk);
        rd_chk("R6", OFF_STS, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule